// File: doc/BRIEF.md
# Next-Fetch-Address Unit with Delayed Redirect

This block owns the fetch address of a 32-bit RISC pipeline. Each cycle it receives the instruction word fetched at the current address together with the two source register values already read for it. From these it works out the following fetch address. Straight-line code advances by one word. A conditional branch compares the two operands for equality or inequality. A region jump builds an absolute target inside the current 256 MB region. A jump-register takes its target from the first operand. A jump-and-link also produces a write of the return address into the link register.

Every taken redirect is delayed by one instruction: the word after the transfer is always fetched before the target. A transfer that appears in that delay slot is not acted on. A register target that is not word aligned raises an address-error flag. The address register advances only while the fetch-enable input is high. A synchronous reset loads a parameterised reset vector and drops any pending redirect. All decode, comparison and target arithmetic settle within one cycle.

Top module: `npc_unit`

## Requirements
- R1: With `rst` high at a clock edge, `pc_o` becomes `RESET_VEC` (default 0x0000_1000) and any pending redirect is discarded, so the next fetch address is `RESET_VEC + 4`.
- R2: When no redirect is pending and the instruction is not a taken transfer, `next_pc_o` is `pc_o + 4` and `pc_o` takes that value at the next enabled edge.
- R3: Opcode bits [31:26] = 0x04 is taken when `rs_val_i == rt_val_i`, and 0x05 when they differ. The target is `pc_o + 4 + (sign-extended bits [15:0] << 2)`.
- R4: Opcodes 0x02 and 0x03 target `{(pc_o+4)[31:28], instr[25:0], 2'b00}`, always taken.
- R5: Opcode 0x03, when acted on, drives `link_we_o` high, `link_idx_o` = 31 and `link_val_o` = `pc_o + 8`. Otherwise `link_we_o` is low.
- R6: Opcode 0x00 with bits [5:0] = 0x08 is taken with target `rs_val_i`. Opcode 0x00 with any other value in bits [5:0] is sequential.
- R7: While a taken transfer is presented, `next_pc_o` is `pc_o + 4` (the delay slot). At the following enabled edge the redirect is pending, and `next_pc_o` shows the target.
- R8: A transfer instruction presented while a redirect is pending is ignored. It causes no redirect, no link write and no address error, and the pending target is still used.
- R9: `addr_err_o` is high when an acted-on register jump has a target with bits [1:0] not zero. The redirect still goes to that target.
- R10: With `fetch_en` low, `pc_o` and the pending redirect hold across the edge, and `link_we_o` and `addr_err_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Allows the address register to advance |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| pc_o | output | 32 | Current fetch address |
| next_pc_o | output | 32 | Address loaded at the next enabled edge |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Link register index (31) |
| link_val_o | output | 32 | Return address to write |
| addr_err_o | output | 1 | Misaligned register-jump target |

## Verification
A vector table walks a program path through equal and unequal operand pairs for both branch senses. This separates the taken and fall-through decisions, and a backward offset shows whether the sign extension is right. The path includes region and linking jumps, aligned and misaligned register jumps, a transfer placed in a delay slot, and a non-jump function code under opcode zero. Directed cases then cover a jump whose delay slot crosses into the next 256 MB region, which shows whether the region bits come from the incremented address. They also cover a stalled fetch both with and without a pending redirect, and a reset taken while a redirect is pending.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_J       = 6'h02;
   localparam logic [5:0] OPC_JAL     = 6'h03;
   localparam logic [5:0] OPC_BEQ     = 6'h04;
   localparam logic [5:0] OPC_BNE     = 6'h05;
   localparam logic [5:0] FN_JR       = 6'h08;

   typedef enum logic [2:0] {
      XFER_NONE,
      XFER_BEQ,
      XFER_BNE,
      XFER_J,
      XFER_JAL,
      XFER_JR
   } xfer_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int OPC_W   = 6,
   parameter int FUNCT_W = 6
) (
   input  logic [OPC_W-1:0]   opc_i,
   input  logic [FUNCT_W-1:0] funct_i,
   output xfer_e              kind_o
);
   if (OPC_W != 6 || FUNCT_W != 6) begin : g_bad_fields
      $error("npc_decode: opcode and function fields must be 6 bits");
   end

   always_comb begin
      kind_o = XFER_NONE;
      unique case (opc_i)
         OPC_BEQ:     kind_o = XFER_BEQ;
         OPC_BNE:     kind_o = XFER_BNE;
         OPC_J:       kind_o = XFER_J;
         OPC_JAL:     kind_o = XFER_JAL;
         OPC_SPECIAL: kind_o = (funct_i == FN_JR) ? XFER_JR : XFER_NONE;
         default:     kind_o = XFER_NONE;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IMM_W    = 16,
   parameter int JADDR_W  = 26,
   localparam int RGN_W   = XLEN - JADDR_W - 2,
   localparam int SEXT_W  = XLEN - IMM_W - 2
) (
   input  logic [XLEN-1:0]    pc_i,
   input  logic [JADDR_W-1:0] field_i,
   input  logic [XLEN-1:0]    rs_val_i,
   input  logic [XLEN-1:0]    rt_val_i,
   input  xfer_e              kind_i,
   output logic [XLEN-1:0]    seq_o,
   output logic               taken_o,
   output logic [XLEN-1:0]    target_o,
   output logic               misalign_o
);
   if (IMM_W >= JADDR_W || RGN_W < 1) begin : g_bad_widths
      $error("npc_target: field widths do not fit the address width");
   end

   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0]  br_off;
   logic             ops_equal;

   assign imm       = field_i[IMM_W-1:0];
   assign seq_o     = pc_i + XLEN'(4);
   assign br_off    = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign ops_equal = (rs_val_i == rt_val_i);

   always_comb begin
      taken_o  = 1'b0;
      target_o = seq_o;
      unique case (kind_i)
         XFER_BEQ: begin
            taken_o  = ops_equal;
            target_o = seq_o + br_off;
         end
         XFER_BNE: begin
            taken_o  = !ops_equal;
            target_o = seq_o + br_off;
         end
         XFER_J, XFER_JAL: begin
            taken_o  = 1'b1;
            target_o = {seq_o[XLEN-1 -: RGN_W], field_i, 2'b00};
         end
         XFER_JR: begin
            taken_o  = 1'b1;
            target_o = rs_val_i;
         end
         default: begin
            taken_o  = 1'b0;
            target_o = seq_o;
         end
      endcase
   end

   assign misalign_o = (kind_i == XFER_JR) && (rs_val_i[1:0] != 2'b00);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              OPC_W      = 6,
   parameter int              FUNCT_W    = 6,
   parameter int              IMM_W      = 16,
   parameter int              JADDR_W    = 26,
   parameter int              REG_W      = 5,
   parameter int              LINK_REG   = 31,
   parameter bit              DELAY_SLOT = 1'b1,
   parameter logic [XLEN-1:0] RESET_VEC  = 'h0000_1000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fetch_en,
   input  logic [XLEN-1:0]  instr_i,
   input  logic [XLEN-1:0]  rs_val_i,
   input  logic [XLEN-1:0]  rt_val_i,
   output logic [XLEN-1:0]  pc_o,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             link_we_o,
   output logic [REG_W-1:0] link_idx_o,
   output logic [XLEN-1:0]  link_val_o,
   output logic             addr_err_o
);
   localparam int INSTR_BYTES = 4;
   localparam int LINK_OFS    = DELAY_SLOT ? 2 * INSTR_BYTES : INSTR_BYTES;

   if (XLEN != OPC_W + JADDR_W) begin : g_bad_xlen
      $error("npc_unit: XLEN must equal opcode plus jump field width");
   end
   if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("npc_unit: reset vector must be word aligned");
   end
   if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
      $error("npc_unit: link register index does not fit REG_W");
   end

   xfer_e            kind;
   logic [XLEN-1:0]  pc_q;
   logic [XLEN-1:0]  seq;
   logic [XLEN-1:0]  tgt;
   logic             taken;
   logic             misalign;
   logic             pend_q;
   logic             act;
   logic             redirect;

   npc_decode #(.OPC_W(OPC_W), .FUNCT_W(FUNCT_W)) u_dec (
      .opc_i   (instr_i[XLEN-1 -: OPC_W]),
      .funct_i (instr_i[FUNCT_W-1:0]),
      .kind_o  (kind)
   );

   npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JADDR_W(JADDR_W)) u_tgt (
      .pc_i       (pc_q),
      .field_i    (instr_i[JADDR_W-1:0]),
      .rs_val_i   (rs_val_i),
      .rt_val_i   (rt_val_i),
      .kind_i     (kind),
      .seq_o      (seq),
      .taken_o    (taken),
      .target_o   (tgt),
      .misalign_o (misalign)
   );

   assign act        = fetch_en && !pend_q;
   assign redirect   = act && taken;
   assign link_we_o  = act && (kind == XFER_JAL);
   assign addr_err_o = act && misalign;
   assign link_idx_o = REG_W'(LINK_REG);
   assign link_val_o = pc_q + XLEN'(LINK_OFS);
   assign pc_o       = pc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= RESET_VEC;
      end else if (fetch_en) begin
         pc_q <= next_pc_o;
      end
   end

   if (DELAY_SLOT) begin : g_slot
      logic [XLEN-1:0] pend_tgt_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            pend_q     <= 1'b0;
            pend_tgt_q <= RESET_VEC;
         end else if (fetch_en) begin
            pend_q     <= redirect;
            pend_tgt_q <= tgt;
         end
      end

      assign next_pc_o = pend_q ? pend_tgt_q : seq;

      // R7
      slot_first_chk: assert property (@(posedge clk) disable iff (rst)
         redirect |=> pend_q && (pc_q == $past(pc_q) + XLEN'(INSTR_BYTES)));

      // R8
      pend_consume_chk: assert property (@(posedge clk) disable iff (rst)
         fetch_en && pend_q |=> !pend_q && (pc_q == $past(pend_tgt_q)));

      // R9
      misalign_flow_chk: assert property (@(posedge clk) disable iff (rst)
         addr_err_o |=> pend_q && (pend_tgt_q[1:0] != 2'b00));
   end else begin : g_noslot
      assign pend_q    = 1'b0;
      assign next_pc_o = taken ? tgt : seq;
   end

   // R1
   reset_vec_chk: assert property (@(posedge clk)
      rst |=> (pc_q == RESET_VEC) && !pend_q);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !fetch_en |=> $stable(pc_q) && $stable(pend_q));

   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      fetch_en && !pend_q && !taken |=> pc_q == $past(pc_q) + XLEN'(INSTR_BYTES));

   // R5
   link_gate_chk: assert property (@(posedge clk) disable iff (rst)
      link_we_o |-> fetch_en && (kind == XFER_JAL));
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
   localparam logic [31:0] NOP  = 32'h0000_0000;
   localparam logic [31:0] BEQ4 = 32'h1000_0004;
   localparam logic [31:0] BNEB = 32'h1400_FFFE;
   localparam logic [31:0] JMAX = 32'h0BFF_FFFF;
   localparam logic [31:0] JAL1 = 32'h0C00_0400;
   localparam logic [31:0] JR   = 32'h0000_0008;
   localparam logic [31:0] J800 = 32'h0800_0800;
   localparam logic [31:0] J10  = 32'h0800_0010;
   localparam logic [31:0] ADDF = 32'h0000_0020;

   typedef struct packed {
      logic [31:0] instr;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [31:0] pc;
      logic [31:0] nxt;
      logic        lwe;
      logic [31:0] lval;
      logic        err;
      logic [23:0] tag;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{NOP,  32'h0,    32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0,    1'b0, "R2 "},
      '{BEQ4, 32'h5,    32'h5, 32'h1004, 32'h1008, 1'b0, 32'h0,    1'b0, "R3 "},
      '{NOP,  32'h0,    32'h0, 32'h1008, 32'h1018, 1'b0, 32'h0,    1'b0, "R7 "},
      '{BEQ4, 32'h5,    32'h6, 32'h1018, 32'h101C, 1'b0, 32'h0,    1'b0, "R3 "},
      '{BNEB, 32'h1,    32'h2, 32'h101C, 32'h1020, 1'b0, 32'h0,    1'b0, "R3 "},
      '{JMAX, 32'h0,    32'h0, 32'h1020, 32'h1018, 1'b0, 32'h0,    1'b0, "R8 "},
      '{BNEB, 32'h7,    32'h7, 32'h1018, 32'h101C, 1'b0, 32'h0,    1'b0, "R3 "},
      '{JAL1, 32'h0,    32'h0, 32'h101C, 32'h1020, 1'b1, 32'h1024, 1'b0, "R5 "},
      '{NOP,  32'h0,    32'h0, 32'h1020, 32'h1000, 1'b0, 32'h0,    1'b0, "R4 "},
      '{JR,   32'h2002, 32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0,    1'b1, "R9 "},
      '{NOP,  32'h0,    32'h0, 32'h1004, 32'h2002, 1'b0, 32'h0,    1'b0, "R6 "},
      '{JR,   32'h1000, 32'h0, 32'h2002, 32'h2006, 1'b0, 32'h0,    1'b0, "R6 "},
      '{ADDF, 32'h3000, 32'h0, 32'h2006, 32'h1000, 1'b0, 32'h0,    1'b0, "R6 "},
      '{J800, 32'h0,    32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0,    1'b0, "R4 "},
      '{NOP,  32'h0,    32'h0, 32'h1004, 32'h2000, 1'b0, 32'h0,    1'b0, "R4 "},
      '{NOP,  32'h0,    32'h0, 32'h2000, 32'h2004, 1'b0, 32'h0,    1'b0, "R2 "}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_en = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] pc, next_pc, link_val;
   logic [4:0]  link_idx;
   logic        link_we, addr_err;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #4 clk = ~clk;

   npc_unit dut (
      .clk        (clk),
      .rst        (rst),
      .fetch_en   (fetch_en),
      .instr_i    (instr),
      .rs_val_i   (rs_val),
      .rt_val_i   (rt_val),
      .pc_o       (pc),
      .next_pc_o  (next_pc),
      .link_we_o  (link_we),
      .link_idx_o (link_idx),
      .link_val_o (link_val),
      .addr_err_o (addr_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input string req, input logic fen, input logic [31:0] ins,
                       input logic [31:0] rsv, input logic [31:0] rtv,
                       input logic [31:0] epc, input logic [31:0] enxt,
                       input logic elwe, input logic [31:0] elval, input logic eerr);
      @(negedge clk);
      check(req, "pc", pc, epc);
      fetch_en = fen;
      instr    = ins;
      rs_val   = rsv;
      rt_val   = rtv;
      #1;
      check(req, "next_pc", next_pc, enxt);
      check(req, "link_we", {31'b0, link_we}, {31'b0, elwe});
      if (elwe) begin
         check(req, "link_val", link_val, elval);
         check(req, "link_idx", {27'b0, link_idx}, 32'd31);
      end
      check(req, "addr_err", {31'b0, addr_err}, {31'b0, eerr});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      fetch_en = 1'b0;
      instr = NOP;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      check("R1", "pc after reset", pc, 32'h1000);

      for (int i = 0; i < NV; i++) begin
         step(string'(VECS[i].tag), 1'b1, VECS[i].instr, VECS[i].rs, VECS[i].rt,
              VECS[i].pc, VECS[i].nxt, VECS[i].lwe, VECS[i].lval, VECS[i].err);
      end

      // R4: jump in the last word of a region takes the next region's bits
      do_reset();
      step("R6", 1'b1, JR,  32'hEFFF_FFF8, 32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0, 1'b0);
      step("R7", 1'b1, NOP, 32'h0, 32'h0, 32'h1004, 32'hEFFF_FFF8, 1'b0, 32'h0, 1'b0);
      step("R2", 1'b1, NOP, 32'h0, 32'h0, 32'hEFFF_FFF8, 32'hEFFF_FFFC, 1'b0, 32'h0, 1'b0);
      step("R4", 1'b1, J10, 32'h0, 32'h0, 32'hEFFF_FFFC, 32'hF000_0000, 1'b0, 32'h0, 1'b0);
      step("R4", 1'b1, NOP, 32'h0, 32'h0, 32'hF000_0000, 32'hF000_0040, 1'b0, 32'h0, 1'b0);
      step("R4", 1'b1, NOP, 32'h0, 32'h0, 32'hF000_0040, 32'hF000_0044, 1'b0, 32'h0, 1'b0);

      // R10: stalled fetch holds the address and suppresses the link write
      do_reset();
      step("R10", 1'b0, JAL1, 32'h0, 32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0, 1'b0);
      step("R10", 1'b1, NOP,  32'h0, 32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0, 1'b0);
      // R10: a stall with a redirect pending keeps it pending
      step("R10", 1'b1, JR,   32'h3000, 32'h0, 32'h1004, 32'h1008, 1'b0, 32'h0, 1'b0);
      step("R10", 1'b0, NOP,  32'h0, 32'h0, 32'h1008, 32'h3000, 1'b0, 32'h0, 1'b0);
      step("R10", 1'b1, NOP,  32'h0, 32'h0, 32'h1008, 32'h3000, 1'b0, 32'h0, 1'b0);
      step("R2",  1'b1, NOP,  32'h0, 32'h0, 32'h3000, 32'h3004, 1'b0, 32'h0, 1'b0);

      // R1: reset while a redirect is pending drops it
      step("R3", 1'b1, BEQ4, 32'h9, 32'h9, 32'h3004, 32'h3008, 1'b0, 32'h0, 1'b0);
      do_reset();
      step("R1", 1'b1, NOP, 32'h0, 32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0, 1'b0);
      step("R2", 1'b1, NOP, 32'h0, 32'h0, 32'h1004, 32'h1008, 1'b0, 32'h0, 1'b0);

      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule